// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block sits between a requester that reads single words and a slower backing memory that delivers whole blocks. Each accepted word address is looked up in the set picked by its index bits. Both ways of that set are compared at once. A hit returns the stored word on the next cycle. A miss stalls the requester, asks the backing memory for the block, writes the block into a chosen way and returns the requested word.

Victim choice is fixed. An empty way is always filled first, lowest number first. When both ways hold valid blocks, a single bit per set names the way to evict. Every hit and every fill points that bit at the other way. The number of sets, the block length in words, the word width and the address width are parameters. Two counters record how many accesses were resolved as hits and as misses.

Top module: `assoc2_cache`

## Requirements
- R1: Reset clears every valid bit, every replacement bit and both counters. After reset `ready` is 1, and `resp_valid` and `mem_req` are 0. The first access to any set is therefore a miss.
- R2: Address fields are unsigned. The offset is the lowest log2(BLK_WORDS) bits and selects the word in the block. The index is the next log2(SETS) bits. The tag is all the remaining upper bits. `mem_addr` is the request address with the offset bits removed. Word k of a block travels on `mem_data[k*DATA_W +: DATA_W]`.
- R3: When a request is accepted (`req` and `ready` both high at a clock edge) and a valid way of the indexed set holds a matching tag, the next cycle shows `resp_valid`=1, `resp_hit`=1 and the stored word on `resp_data`. No memory request is made.
- R4: On an accepted request that misses, the next cycle shows `mem_req`=1 with the block address and `ready`=0, and `mem_addr` holds steady until `mem_valid`. In the cycle after `mem_valid`, the block has been installed, `mem_req` is 0, `ready` is 1, and `resp_valid`=1 with `resp_hit`=0 and the requested word from the delivered block.
- R5: On a miss, if a way of the set is invalid, the block goes into the lowest-numbered invalid way.
- R6: On a miss with both ways valid, the way named by the set's replacement bit is overwritten.
- R7: Each hit, and each fill, makes the other way of that set the next victim. With two sets and block addresses 0,2,0,1,4,0,2,3,5,4, the outcomes are miss, miss, hit, miss, miss, hit, miss, miss, miss, miss.
- R8: `hit_cnt` increases by one with each hit response and `miss_cnt` with each miss response. Neither changes in any other cycle.
- R9: `req` is ignored while `ready` is 0. A request presented during a stall starts no second memory request and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request |
| addr | input | ADDR_W | Word address of the request |
| ready | output | 1 | Cache can accept a request this cycle |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Response was served from the cache |
| resp_data | output | DATA_W | Requested word |
| mem_req | output | 1 | Block fetch request to backing memory |
| mem_addr | output | ADDR_W-log2(BLK_WORDS) | Block address being fetched |
| mem_valid | input | 1 | Backing memory delivers the block this cycle |
| mem_data | input | DATA_W*BLK_WORDS | Delivered block, word k in slice k |
| hit_cnt | output | CNT_W | Count of hit responses |
| miss_cnt | output | CNT_W | Count of miss responses |

## Verification
The bench uses two sets and two-word blocks. A fixed sequence of block addresses separates first-empty-way placement from replacement-bit eviction, because the hit/miss outcome of its later accesses flips if either rule is wrong. A second access to the other word of a resident block shows that the offset selects the word within the block. An ascending sweep over the whole address space, followed by several hundred pseudo-random addresses, is compared against an arithmetic model of the valid, tag and replacement state. This exposes errors in tag or index extraction, data selection and counter updates. Requests asserted during a stall show that a busy cache takes in nothing.

// File: rtl/assoc2_cache_pkg.sv
package assoc2_cache_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } fill_state_e;

   localparam int unsigned NUM_WAYS = 2;

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned TAG_W  = 10,
   parameter int unsigned OFF_WS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [IDX_W-1:0]  idx,
   output logic [OFF_WS-1:0] off
);

   if (OFF_W == 0) begin : g_no_off
      assign off = '0;
      assign idx = addr[IDX_W-1:0];
   end else begin : g_off
      assign off = addr[OFF_W-1:0];
      assign idx = addr[OFF_W+IDX_W-1:OFF_W];
   end

   assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/cache_way_array.sv
module cache_way_array #(
   parameter int unsigned SETS  = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 10,
   parameter int unsigned BLK_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] cmp_tag,
   output logic             rd_valid,
   output logic             rd_match,
   output logic [BLK_W-1:0] rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [BLK_W-1:0] wr_data
);

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q  [SETS];
   logic [BLK_W-1:0] data_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
   assign rd_match = rd_valid && (tag_q[rd_idx] == cmp_tag);

endmodule

// File: rtl/cache_lru_bits.sv
module cache_lru_bits #(
   parameter int unsigned SETS  = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_victim,
   input  logic             upd,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_way
);

   logic [SETS-1:0] victim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         victim_q <= '0;
      end else if (upd) begin
         victim_q[upd_idx] <= ~upd_way;
      end
   end

   assign rd_victim = victim_q[rd_idx];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import assoc2_cache_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned OFF_WS = 2,
   parameter int unsigned BLK_W  = 128,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [OFF_WS-1:0] acc_off,
   input  logic [1:0]        hit_vec,
   input  logic [1:0]        way_valid,
   input  logic              lru_victim,
   input  logic [BLK_W-1:0]  hit_blk,
   input  logic              mem_valid,
   input  logic [BLK_W-1:0]  mem_data,
   input  logic [OFF_WS-1:0] pend_off,
   output logic              ready,
   output logic              mem_req,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [1:0]        wr_en,
   output logic              lru_upd,
   output logic              fill_now,
   output logic              use_way,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_data,
   output logic [CNT_W-1:0]  hit_cnt,
   output logic [CNT_W-1:0]  miss_cnt
);

   fill_state_e       state_q;
   logic              victim_q;
   logic              accept;
   logic              any_hit;
   logic              hit_now;
   logic              pick_way;
   logic [DATA_W-1:0] hit_word;
   logic [DATA_W-1:0] fill_word;

   if (OFF_W == 0) begin : g_one_word
      assign hit_word  = hit_blk[DATA_W-1:0];
      assign fill_word = mem_data[DATA_W-1:0];
   end else begin : g_many_words
      assign hit_word  = hit_blk[acc_off*DATA_W +: DATA_W];
      assign fill_word = mem_data[pend_off*DATA_W +: DATA_W];
   end

   assign ready    = (state_q == ST_IDLE);
   assign accept   = req && ready;
   assign any_hit  = |hit_vec;
   assign hit_now  = accept && any_hit;
   assign fill_now = (state_q == ST_FILL) && mem_valid;
   assign lru_upd  = hit_now || fill_now;
   assign use_way  = fill_now ? victim_q : hit_vec[1];

   always_comb begin
      if (!way_valid[0]) begin
         pick_way = 1'b0;
      end else if (!way_valid[1]) begin
         pick_way = 1'b1;
      end else begin
         pick_way = lru_victim;
      end
   end

   for (genvar w = 0; w < 2; w++) begin : g_wen
      assign wr_en[w] = fill_now && (victim_q == w[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         victim_q   <= 1'b0;
         mem_req    <= 1'b0;
         pend_addr  <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_data  <= '0;
         hit_cnt    <= '0;
         miss_cnt   <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (any_hit) begin
                     resp_valid <= 1'b1;
                     resp_hit   <= 1'b1;
                     resp_data  <= hit_word;
                     hit_cnt    <= hit_cnt + CNT_W'(1);
                  end else begin
                     state_q   <= ST_FILL;
                     pend_addr <= addr;
                     victim_q  <= pick_way;
                     mem_req   <= 1'b1;
                  end
               end
            end
            ST_FILL: begin
               if (mem_valid) begin
                  state_q    <= ST_IDLE;
                  mem_req    <= 1'b0;
                  resp_valid <= 1'b1;
                  resp_hit   <= 1'b0;
                  resp_data  <= fill_word;
                  miss_cnt   <= miss_cnt + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SETS      = 16,
   parameter int unsigned BLK_WORDS = 4,
   parameter int unsigned CNT_W     = 16,
   localparam int unsigned OFF_W    = $clog2(BLK_WORDS),
   localparam int unsigned IDX_W    = $clog2(SETS),
   localparam int unsigned BLK_AW   = ADDR_W - OFF_W,
   localparam int unsigned BLK_W    = DATA_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_data,
   output logic              mem_req,
   output logic [BLK_AW-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [BLK_W-1:0]  mem_data,
   output logic [CNT_W-1:0]  hit_cnt,
   output logic [CNT_W-1:0]  miss_cnt
);

   localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int unsigned OFF_WS = (OFF_W > 0) ? OFF_W : 1;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("assoc2_cache: SETS must be a power of two and at least 2");
   end
   if (BLK_WORDS < 1 || (BLK_WORDS & (BLK_WORDS - 1)) != 0) begin : g_bad_blk
      $error("assoc2_cache: BLK_WORDS must be a power of two");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
      $error("assoc2_cache: ADDR_W leaves no tag bits");
   end

   logic [TAG_W-1:0]  acc_tag,  pend_tag;
   logic [IDX_W-1:0]  acc_idx,  pend_idx;
   logic [OFF_WS-1:0] acc_off,  pend_off;
   logic [ADDR_W-1:0] pend_addr;
   logic [1:0]        hit_vec;
   logic [1:0]        way_valid;
   logic [1:0]        wr_en;
   logic [BLK_W-1:0]  way_data [2];
   logic [BLK_W-1:0]  hit_blk;
   logic              lru_victim;
   logic              lru_upd;
   logic              fill_now;
   logic              use_way;

   cache_addr_split #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_WS(OFF_WS)
   ) acc_split_i (
      .addr(addr), .tag(acc_tag), .idx(acc_idx), .off(acc_off)
   );

   cache_addr_split #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_WS(OFF_WS)
   ) pend_split_i (
      .addr(pend_addr), .tag(pend_tag), .idx(pend_idx), .off(pend_off)
   );

   for (genvar w = 0; w < 2; w++) begin : g_way
      cache_way_array #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)
      ) way_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (acc_idx),
         .cmp_tag  (acc_tag),
         .rd_valid (way_valid[w]),
         .rd_match (hit_vec[w]),
         .rd_data  (way_data[w]),
         .wr_en    (wr_en[w]),
         .wr_idx   (pend_idx),
         .wr_tag   (pend_tag),
         .wr_data  (mem_data)
      );
   end

   assign hit_blk = hit_vec[1] ? way_data[1] : way_data[0];

   cache_lru_bits #(
      .SETS(SETS), .IDX_W(IDX_W)
   ) lru_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (acc_idx),
      .rd_victim (lru_victim),
      .upd       (lru_upd),
      .upd_idx   (fill_now ? pend_idx : acc_idx),
      .upd_way   (use_way)
   );

   cache_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .OFF_WS(OFF_WS),
      .BLK_W(BLK_W), .CNT_W(CNT_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .addr       (addr),
      .acc_off    (acc_off),
      .hit_vec    (hit_vec),
      .way_valid  (way_valid),
      .lru_victim (lru_victim),
      .hit_blk    (hit_blk),
      .mem_valid  (mem_valid),
      .mem_data   (mem_data),
      .pend_off   (pend_off),
      .ready      (ready),
      .mem_req    (mem_req),
      .pend_addr  (pend_addr),
      .wr_en      (wr_en),
      .lru_upd    (lru_upd),
      .fill_now   (fill_now),
      .use_way    (use_way),
      .resp_valid (resp_valid),
      .resp_hit   (resp_hit),
      .resp_data  (resp_data),
      .hit_cnt    (hit_cnt),
      .miss_cnt   (miss_cnt)
   );

   assign mem_addr = {pend_tag, pend_idx};

endmodule

// File: rtl/assoc2_cache_chk.sv
module assoc2_cache_chk #(
   parameter int unsigned BLK_AW = 14,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              ready,
   input logic              resp_valid,
   input logic              resp_hit,
   input logic              mem_req,
   input logic [BLK_AW-1:0] mem_addr,
   input logic              mem_valid,
   input logic [CNT_W-1:0]  hit_cnt,
   input logic [CNT_W-1:0]  miss_cnt
);

   AST_ACCEPT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> ((resp_valid && resp_hit) || (mem_req && !ready && !resp_valid))); // R3

   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ready); // R9

   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R4

   AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid) |=> (resp_valid && !resp_hit && !mem_req && ready)); // R4

   AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit) |-> (hit_cnt == $past(hit_cnt) + CNT_W'(1))); // R8

   AST_MISS_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (miss_cnt == $past(miss_cnt) + CNT_W'(1))); // R8

   AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> ($stable(hit_cnt) && $stable(miss_cnt))); // R8

endmodule

bind assoc2_cache assoc2_cache_chk #(
   .BLK_AW(BLK_AW), .CNT_W(CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .ready      (ready),
   .resp_valid (resp_valid),
   .resp_hit   (resp_hit),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_valid  (mem_valid),
   .hit_cnt    (hit_cnt),
   .miss_cnt   (miss_cnt)
);

// File: tb/assoc2_cache_tb_top.sv
`timescale 1ns/1ps
module assoc2_cache_tb_top;

   localparam int unsigned AW  = 8;
   localparam int unsigned DW  = 16;
   localparam int unsigned NS  = 2;
   localparam int unsigned BW  = 2;
   localparam int unsigned CW  = 16;
   localparam int unsigned LAT = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic            ready, resp_valid, resp_hit, mem_req;
   logic [DW-1:0]   resp_data;
   logic [AW-2:0]   mem_addr;
   logic            mem_valid = 1'b0;
   logic [2*DW-1:0] mem_data = '0;
   logic [CW-1:0]   hit_cnt, miss_cnt;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int lat_cnt = 0;

   logic       mv [2][2];
   logic [5:0] mt [2][2];
   logic       ml [2];
   int         m_hits = 0;
   int         m_miss = 0;

   always #4 clk = ~clk;

   assoc2_cache #(
      .ADDR_W(AW), .DATA_W(DW), .SETS(NS), .BLK_WORDS(BW), .CNT_W(CW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ready(ready),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_data(mem_data), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
   );

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a, ~a};
   endfunction

   function automatic logic [2*DW-1:0] block_of(input logic [AW-2:0] b);
      return {word_of({b, 1'b1}), word_of({b, 1'b0})};
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // backing memory: answers LAT cycles after a request appears
   always @(negedge clk) begin
      if (mem_valid) begin
         mem_valid = 1'b0;
      end else if (rst_n && mem_req) begin
         if (lat_cnt == LAT) begin
            mem_valid = 1'b1;
            mem_data  = block_of(mem_addr);
            lat_cnt   = 0;
         end else begin
            lat_cnt++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // reference model lookup and update, returns expected hit
   function automatic bit model_access(input logic [AW-1:0] a);
      int s;
      logic [5:0] t;
      int w;
      bit h;
      s = int'(a[1]);
      t = a[7:2];
      h = 1'b0;
      w = 0;
      if (mv[s][0] && mt[s][0] == t) begin h = 1'b1; w = 0; end
      else if (mv[s][1] && mt[s][1] == t) begin h = 1'b1; w = 1; end
      if (!h) begin
         if (!mv[s][0]) w = 0;
         else if (!mv[s][1]) w = 1;
         else w = int'(ml[s]);
         mv[s][w] = 1'b1;
         mt[s][w] = t;
         m_miss++;
      end else begin
         m_hits++;
      end
      ml[s] = (w == 0) ? 1'b1 : 1'b0;
      return h;
   endfunction

   task automatic access(input logic [AW-1:0] a, input bit noise, output bit got_hit);
      bit exp_hit;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req  = 1'b1;
      addr = a;
      exp_hit = model_access(a);
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      if (exp_hit) begin
         chk(resp_valid && resp_hit, "R3 hit next cycle", {resp_valid, resp_hit}, 2'b11);
         chk(!mem_req, "R3 no fetch on hit", mem_req, 0);
      end else begin
         chk(mem_req && !ready && !resp_valid, "R4 miss stalls and fetches",
             {mem_req, ready, resp_valid}, 3'b100);
         chk(mem_addr == a[AW-1:1], "R2 block address", mem_addr, a[AW-1:1]);
         while (!resp_valid) begin
            if (noise) begin
               req  = mem_req;
               addr = a ^ 8'h80;
            end
            @(negedge clk);
         end
         req = 1'b0;
         chk(!resp_hit && !mem_req && ready, "R4 fill response",
             {resp_hit, mem_req, ready}, 3'b001);
      end
      got_hit = resp_hit;
      chk(resp_hit == exp_hit, "R5 R6 R7 outcome matches model", resp_hit, exp_hit);
      chk(resp_data == word_of(a), "R2 word selected by offset", resp_data, word_of(a));
      chk(hit_cnt == CW'(m_hits), "R8 hit counter", hit_cnt, m_hits);
      chk(miss_cnt == CW'(m_miss), "R8 miss counter", miss_cnt, m_miss);
      if (noise) begin
         @(negedge clk);
         chk(!resp_valid && !mem_req && ready, "R9 stalled request ignored",
             {resp_valid, mem_req, ready}, 3'b001);
         chk(miss_cnt == CW'(m_miss) && hit_cnt == CW'(m_hits), "R9 counters unchanged",
             miss_cnt, m_miss);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         ml[s] = 1'b0;
         for (int w = 0; w < 2; w++) begin
            mv[s][w] = 1'b0;
            mt[s][w] = '0;
         end
      end
      m_hits = 0;
      m_miss = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req   = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
   endtask

   initial begin
      bit h;
      int blocks [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
      bit pattern [10] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
      logic [15:0] lcg;

      do_reset();
      // R1 reset state
      chk(ready == 1'b1, "R1 ready after reset", ready, 1);
      chk(!resp_valid && !mem_req, "R1 idle outputs", {resp_valid, mem_req}, 0);
      chk(hit_cnt == 0 && miss_cnt == 0, "R1 counters cleared", {hit_cnt, miss_cnt}, 0);

      // R7 reference sequence on block addresses, word 0 of each block
      for (int i = 0; i < 10; i++) begin
         access(AW'(blocks[i] * 2), 1'b0, h);
         chk(h == pattern[i], "R7 reference sequence", h, pattern[i]);
      end
      // R2 the second word of resident blocks 4 and 2
      access(8'd9, 1'b0, h);
      chk(h == 1'b1, "R2 other word of resident block hits", h, 1);
      access(8'd5, 1'b0, h);
      chk(h == 1'b1, "R2 other word of resident block 2 hits", h, 1);
      // R1 the first access to set 0 after a fresh reset misses
      do_reset();
      access(8'd0, 1'b0, h);
      chk(h == 1'b0, "R1 first access misses", h, 0);
      // R6 conflict: three tags in one set, eviction follows replacement bit
      access(8'd4, 1'b0, h);
      access(8'd0, 1'b0, h);
      access(8'd8, 1'b0, h);
      chk(h == 1'b0, "R6 third tag misses", h, 0);
      access(8'd0, 1'b0, h);
      chk(h == 1'b1, "R6 recently used block kept", h, 1);
      access(8'd4, 1'b0, h);
      chk(h == 1'b0, "R6 least recent block evicted", h, 0);
      // R9 requests during a stall
      access(8'h40, 1'b1, h);
      access(8'h62, 1'b1, h);

      // ascending sweep of every address
      do_reset();
      for (int a = 0; a < 256; a++) begin
         access(AW'(a), 1'b0, h);
      end
      // pseudo-random traffic
      lcg = 16'h1d3b;
      for (int i = 0; i < 600; i++) begin
         lcg = lcg * 16'd25173 + 16'd13849;
         access(lcg[11:4], (i % 97) == 0, h);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule